// File: doc/BRIEF.md
# Tagged Branch Prediction Table with Start-up Clear

This block is a direct-mapped prediction table. Each slot holds a 2-bit confidence status, a 16-bit tag and a 32-bit predicted target. A fetch address drives the lookup side. Its middle bits select a slot and its top 16 bits are compared with the stored tag. The result (status and target, or zero on a miss) is registered and appears one clock later. A separate update side writes a whole slot when its enable is high.

The storage is plain clocked registers with no reset, so it is not cleared by reset. Instead, a small sequencer takes over the single write port after every reset. It writes zero into one slot per clock until every slot is clean, and only then raises `ready`. While the walk runs, lookups report zero and update requests are dropped. The table depth is set by the index width parameter, which is kept small by default.

Top module: `bpt_table`

## Requirements
- R1: The slot index is `addr[IDX_LO+IDX_W-1:IDX_LO]` (bits 5..2 by default) and the tag is `addr[31:16]`. No other address bit affects a lookup or an update.
- R2: The result of a lookup appears on `pred_status`/`pred_target` after the first rising clock edge that samples `lk_addr`, and it is held until the next edge.
- R3: A lookup hits only when the stored tag equals `lk_addr[31:16]` and the stored status is not zero. On a miss, both `pred_status` and `pred_target` are zero.
- R4: With `ready` high and `upd_en` high at a clock edge, the slot selected by `upd_addr` takes `upd_status`, `upd_addr[31:16]` and `upd_target`.
- R5: With `upd_en` low, no slot changes.
- R6: While `rst_n` is low, `ready`, `pred_status` and `pred_target` are all zero.
- R7: While `ready` is low, every lookup returns zero and update requests have no effect.
- R8: `ready` rises on exactly the 2**IDX_W-th rising edge after reset is released, then stays high until the next reset.
- R9: Asserting reset at any time restarts the clear walk from slot 0. After it completes, every slot reads as a miss.
- R10: When a lookup and an update hit the same slot at the same edge, the lookup returns the contents from before the write. The next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; starts the clear walk |
| lk_addr | input | 32 | Lookup address |
| upd_en | input | 1 | Update write enable |
| upd_addr | input | 32 | Update address (selects slot, supplies tag) |
| upd_status | input | 2 | Status to store |
| upd_target | input | 32 | Predicted target to store |
| ready | output | 1 | High once the clear walk has finished |
| pred_status | output | 2 | Registered status of the lookup, zero on miss |
| pred_target | output | 32 | Registered target of the lookup, zero on miss |

## Verification
A lookup result is due one edge after its address is sampled. An update becomes visible to a lookup sampled at the following edge, and `ready` is due at edge 2**IDX_W after reset is released. The bench drives inputs and compares outputs at the falling edge. A behavioural model updates at each rising edge: it computes the lookup result from its stored contents before it applies that edge's write. Every compare therefore lands half a cycle after the edge that produced the value. The checker counts edges since reset to place the rise of `ready` exactly.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    parameter int STAT_W = 2;
    parameter int TAG_W  = 16;
    parameter int TGT_W  = 32;

    typedef logic [STAT_W-1:0] stat_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [TGT_W-1:0]  tgt_t;

    typedef struct packed {
        stat_t stat;
        tag_t  tag;
        tgt_t  tgt;
    } bpt_entry_t;

    localparam bpt_entry_t ENTRY_ZERO = '0;

endpackage

// File: rtl/bpt_clear_seq.sv
module bpt_clear_seq
    import bpt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             clr_active,
    output logic [IDX_W-1:0] clr_idx,
    output logic             ready
);

    localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

    typedef enum logic {
        ST_WALK,
        ST_RUN
    } clr_state_e;

    typedef struct packed {
        clr_state_e       state;
        logic [IDX_W-1:0] ptr;
        logic             ready;
    } clr_regs_t;

    clr_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_WALK: begin
                if (r_q.ptr == LAST_IDX) begin
                    r_d.state = ST_RUN;
                    r_d.ready = 1'b1;
                    r_d.ptr   = '0;
                end else begin
                    r_d.ptr = r_q.ptr + 1'b1;
                end
            end
            default: begin
                r_d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_WALK, ptr: '0, ready: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign clr_active = (r_q.state == ST_WALK);
    assign clr_idx    = r_q.ptr;
    assign ready      = r_q.ready;

endmodule

// File: rtl/bpt_array.sv
module bpt_array
    import bpt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  bpt_entry_t       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output bpt_entry_t       rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    bpt_entry_t slot_vec [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        bpt_entry_t slot_d, slot_q;
        logic       sel;

        assign sel = wr_en && (wr_idx == IDX_W'(gi));

        always_comb begin
            slot_d = slot_q;
            if (sel) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            slot_q <= slot_d;
        end

        assign slot_vec[gi] = slot_q;
    end

    assign rd_data = slot_vec[rd_idx];

endmodule

// File: rtl/bpt_lookup.sv
module bpt_lookup
    import bpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ready,
    input  tag_t       lk_tag,
    input  bpt_entry_t rd_data,
    output stat_t      pred_status,
    output tgt_t       pred_target
);

    typedef struct packed {
        stat_t stat;
        tgt_t  tgt;
    } pred_regs_t;

    pred_regs_t p_d, p_q;
    logic       hit;

    always_comb begin
        hit = ready && (rd_data.tag == lk_tag) && (rd_data.stat != '0);
        p_d = '0;
        if (hit) begin
            p_d.stat = rd_data.stat;
            p_d.tgt  = rd_data.tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign pred_status = p_q.stat;
    assign pred_target = p_q.tgt;

endmodule

// File: rtl/bpt_table.sv
module bpt_table
    import bpt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_LO = 2,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [STAT_W-1:0] upd_status,
    input  logic [TGT_W-1:0]  upd_target,
    output logic              ready,
    output logic [STAT_W-1:0] pred_status,
    output logic [TGT_W-1:0]  pred_target
);

    localparam int TAG_LO = ADDR_W - TAG_W;

    logic [IDX_W-1:0] lk_idx, upd_idx, clr_idx, wr_idx;
    tag_t             lk_tag, upd_tag;
    logic             clr_active, wr_en;
    bpt_entry_t       wr_data, rd_data;
    logic             unused_addr_bits;

    assign lk_idx  = lk_addr[IDX_LO +: IDX_W];
    assign upd_idx = upd_addr[IDX_LO +: IDX_W];
    assign lk_tag  = lk_addr[TAG_LO +: TAG_W];
    assign upd_tag = upd_addr[TAG_LO +: TAG_W];
    assign unused_addr_bits = ^{lk_addr, upd_addr};

    bpt_clear_seq #(.IDX_W(IDX_W)) i_clear (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_active (clr_active),
        .clr_idx    (clr_idx),
        .ready      (ready)
    );

    // Write-port mux: the clear walk owns the port until it is done.
    always_comb begin
        if (clr_active) begin
            wr_en   = 1'b1;
            wr_idx  = clr_idx;
            wr_data = ENTRY_ZERO;
        end else begin
            wr_en   = upd_en && ready;
            wr_idx  = upd_idx;
            wr_data = '{stat: upd_status, tag: upd_tag, tgt: upd_target};
        end
    end

    bpt_array #(.IDX_W(IDX_W)) i_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (lk_idx),
        .rd_data (rd_data)
    );

    bpt_lookup i_lookup (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready       (ready),
        .lk_tag      (lk_tag),
        .rd_data     (rd_data),
        .pred_status (pred_status),
        .pred_target (pred_target)
    );

endmodule

// File: rtl/bpt_table_chk.sv
module bpt_table_chk
    import bpt_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ready,
    input stat_t       pred_status,
    input tgt_t        pred_target
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = IDX_W + 2;

    logic [CNT_W-1:0] edge_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
        end else if (edge_cnt_q < CNT_W'(DEPTH)) begin
            edge_cnt_q <= edge_cnt_q + 1'b1;
        end
    end

    // R8
    ready_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (edge_cnt_q >= CNT_W'(DEPTH)));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R7
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (pred_status == '0 && pred_target == '0));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_status == '0) |-> (pred_target == '0));

endmodule

bind bpt_table bpt_table_chk #(.IDX_W(IDX_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .pred_status (pred_status),
    .pred_target (pred_target)
);

// File: tb/test_bpt_table.sv
module test_bpt_table;

    localparam int IDX_LO = 2;
    localparam int IDX_W  = 4;
    localparam int DEPTH  = 1 << IDX_W;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_addr = '0;
    logic [1:0]  upd_status = '0;
    logic [31:0] upd_target = '0;
    logic        ready;
    logic [1:0]  pred_status;
    logic [31:0] pred_target;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R6";

    always #4 clk = ~clk;

    bpt_table #(.ADDR_W(32), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) i_bpt_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_addr     (lk_addr),
        .upd_en      (upd_en),
        .upd_addr    (upd_addr),
        .upd_status  (upd_status),
        .upd_target  (upd_target),
        .ready       (ready),
        .pred_status (pred_status),
        .pred_target (pred_target)
    );

    // Behavioural reference model
    logic [1:0]  m_st [DEPTH];
    logic [15:0] m_tg [DEPTH];
    logic [31:0] m_tt [DEPTH];
    int          m_cnt = 0;
    logic [1:0]  e_st = '0;
    logic [31:0] e_tt = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            e_st  = '0;
            e_tt  = '0;
        end else begin
            int li;
            li = int'(lk_addr[IDX_LO +: IDX_W]);
            if (m_cnt >= DEPTH && m_tg[li] == lk_addr[31:16] && m_st[li] != 2'd0) begin
                e_st = m_st[li];
                e_tt = m_tt[li];
            end else begin
                e_st = '0;
                e_tt = '0;
            end
            if (m_cnt < DEPTH) begin
                m_st[m_cnt] = '0;
                m_tg[m_cnt] = '0;
                m_tt[m_cnt] = '0;
                m_cnt++;
            end else if (upd_en) begin
                int ui;
                ui = int'(upd_addr[IDX_LO +: IDX_W]);
                m_st[ui] = upd_status;
                m_tg[ui] = upd_addr[31:16];
                m_tt[ui] = upd_target;
            end
        end
    end

    function automatic logic [31:0] mk(input logic [15:0] tag, input int idx);
        logic [31:0] a;
        a = $urandom;
        a[31:16] = tag;
        a[IDX_LO +: IDX_W] = idx[IDX_W-1:0];
        return a;
    endfunction

    task automatic tick();
        logic e_rdy;
        @(negedge clk);
        e_rdy = (m_cnt >= DEPTH);
        n_vec++;
        if (ready !== e_rdy || pred_status !== e_st || pred_target !== e_tt) begin
            n_bad++;
            $display("FAIL %s: ready=%0b exp %0b, status=%0h exp %0h, target=%08h exp %08h",
                     cur_req, ready, e_rdy, pred_status, e_st, pred_target, e_tt);
        end
    endtask

    task automatic put(input logic [15:0] tag, input int idx, input logic [1:0] st, input logic [31:0] tt);
        upd_en     = 1'b1;
        upd_addr   = mk(tag, idx);
        upd_status = st;
        upd_target = tt;
    endtask

    initial begin
        // R6: reset state
        cur_req = "R6";
        repeat (3) tick();

        // R7 R8: clear walk, lookups zero, updates dropped, ready timing
        cur_req = "R7 R8";
        rst_n = 1'b1;
        lk_addr = mk(16'h1234, 0);
        for (int k = 0; k < DEPTH; k++) begin
            if (k >= 4) put(16'h1234, 0, 2'd3, 32'hCAFE_0000 + k);
            tick();
        end
        upd_en = 1'b0;
        cur_req = "R7";
        repeat (2) tick();

        // R2 R4: write then registered lookup
        cur_req = "R2 R4";
        put(16'hAAAA, 3, 2'd2, 32'hDEAD_BEEF);
        tick();
        upd_en = 1'b0;
        lk_addr = mk(16'hAAAA, 3);
        tick();
        tick();

        // R1: unrelated address bits ignored
        cur_req = "R1";
        for (int k = 0; k < 4; k++) begin
            lk_addr = mk(16'hAAAA, 3);
            tick();
        end

        // R3: tag mismatch and zero status both miss
        cur_req = "R3";
        lk_addr = mk(16'hAAAB, 3);
        tick();
        put(16'hBBBB, 5, 2'd0, 32'h1234_5678);
        tick();
        upd_en = 1'b0;
        lk_addr = mk(16'hBBBB, 5);
        tick();
        tick();

        // R5: disabled update leaves slot unchanged
        cur_req = "R5";
        put(16'hCCCC, 3, 2'd1, 32'h0BAD_0BAD);
        upd_en = 1'b0;
        tick();
        lk_addr = mk(16'hAAAA, 3);
        tick();
        tick();

        // R10: same-slot read during write returns old contents
        cur_req = "R10";
        lk_addr = mk(16'hAAAA, 3);
        put(16'hAAAA, 3, 2'd1, 32'h5555_AAAA);
        tick();
        upd_en = 1'b0;
        tick();
        tick();

        // R9: reset restarts the walk, table is cleared
        cur_req = "R9";
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        repeat (7) tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        repeat (DEPTH + 1) tick();
        lk_addr = mk(16'hAAAA, 3);
        tick();
        tick();

        // R1 R3 R4 R5 R10: mixed traffic
        cur_req = "R1 R3 R4 R5 R10";
        for (int k = 0; k < 400; k++) begin
            logic [15:0] tg;
            tg = ($urandom_range(0, 1) == 0) ? 16'h1111 : 16'h2222;
            lk_addr = mk(tg, int'($urandom_range(0, DEPTH - 1)));
            upd_en = ($urandom_range(0, 2) == 0);
            upd_addr = mk(($urandom_range(0, 1) == 0) ? 16'h1111 : 16'h2222,
                          int'($urandom_range(0, DEPTH - 1)));
            upd_status = 2'($urandom_range(0, 3));
            upd_target = $urandom;
            tick();
        end
        upd_en = 1'b0;
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung, expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule